// File: doc/BRIEF.md
# Raster Line Pixel Generator

This block is a small drawing coprocessor. It takes two endpoints on an unsigned integer grid and walks the straight raster line between them, producing one pixel coordinate per clock. The four endpoint coordinates are written one at a time from a shared data bus, with a separate load strobe for each. A start pulse then begins the walk.

The walk is the classic integer error-accumulator line algorithm, and it works in all octants. At setup the block forms the absolute spans on both axes, a step direction for each axis, and an initial error equal to the X span minus the Y span. On each step it doubles the error and runs two independent tests against it. One test may advance X and the other may advance Y, so a diagonal step moves both coordinates in the same cycle. Only addition, subtraction and comparison are needed.

While a line is being drawn, the block holds a busy flag high and marks every cycle with a valid flag. It emits the start point first and the end point last. It then returns to idle and keeps the endpoints, so a new start pulse redraws the same line.

Top module: `line_pixel_gen`

## Requirements
- R1: Each load strobe (loadX1, loadY1, loadX2, loadY2) captures dataIn into its own endpoint coordinate on the clock edge where it is high while the block is idle.
- R2: After reset, busy and pixelValid are both low and stay low until a start pulse arrives.
- R3: A start pulse while idle makes busy and pixelValid high one cycle later, with (pixelX, pixelY) equal to the start point (X1, Y1).
- R4: While busy, pixelValid is high in every cycle. From one pixel to the next, each coordinate changes by -1, 0 or +1, and at least one of them changes.
- R5: The last pixel presented is the end point (X2, Y2). busy and pixelValid are low in the cycle after it.
- R6: The pixel sequence matches the error-accumulator rule. With e2 = 2*err, X steps toward X2 and err decreases by dy when e2 > -dy. Y steps toward Y2 and err increases by dx when e2 < dx. Both tests use the same e2. For example, (787,590)->(647,812) begins (787,590), (786,591), (786,592).
- R7: When the start point equals the end point, exactly one pixel is emitted and busy lasts one cycle.
- R8: A start pulse or load strobe that arrives while busy is high has no effect on the line being drawn or on the stored endpoints.
- R9: The endpoints are kept after a line ends. A new start pulse with no loads redraws the identical line.
- R10: A line emits exactly max(|X2-X1|, |Y2-Y1|) + 1 pixels, including lines that span the full coordinate range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| resetn | input | 1 | Synchronous reset, active low |
| dataIn | input | COORD_W | Coordinate value for the load strobes |
| loadX1 | input | 1 | Capture dataIn as start X |
| loadY1 | input | 1 | Capture dataIn as start Y |
| loadX2 | input | 1 | Capture dataIn as end X |
| loadY2 | input | 1 | Capture dataIn as end Y |
| start | input | 1 | Begin drawing the stored line |
| pixelX | output | COORD_W | Current pixel X |
| pixelY | output | COORD_W | Current pixel Y |
| pixelValid | output | 1 | pixelX/pixelY hold a line pixel |
| busy | output | 1 | Line drawing in progress |

## Verification
The hardest conditions to reach are the error-accumulator ties, where doubling the error lands exactly on one of the two thresholds, and the octant boundaries with zero spans. The bench reaches them by sweeping every endpoint pair on a four-by-four patch of the grid, both near zero and against the top of the range. It also draws full-range diagonal and shallow lines and a long steep line. To show that strobes arriving mid-line are ignored, a start pulse and an end-point load are injected partway through a line. The line is then redrawn with no reloads, and the redraw must match the original.

// File: rtl/line_pkg.sv
package line_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic init;   // latch setup values, begin at start point
    logic step;   // advance one pixel along the line
  } lineCmd_t;
endpackage

// File: rtl/line_datapath.sv
module line_datapath
  import line_pkg::*;
#(
  parameter int COORD_W = 10
) (
  input  logic               clk,
  input  logic               resetn,
  input  logic [COORD_W-1:0] dataIn,
  input  logic               loadX1,
  input  logic               loadY1,
  input  logic               loadX2,
  input  logic               loadY2,
  input  logic               busy,
  input  lineCmd_t           cmd,
  output logic               atEnd,
  output logic [COORD_W-1:0] curX,
  output logic [COORD_W-1:0] curY
);
  // two guard bits: one for sign, one for doubling the error
  localparam int ERR_W = COORD_W + 2;
  localparam int PAD_W = ERR_W - COORD_W;
  localparam logic [COORD_W-1:0] ONE = COORD_W'(1);

  logic [COORD_W-1:0] x1R, y1R, x2R, y2R;
  logic signed [ERR_W-1:0] dxR, dyR, errR;
  logic sxNeg, syNeg;

  // endpoint registers, writable only when idle
  always_ff @(posedge clk) begin
    if (!resetn) begin
      x1R <= '0; y1R <= '0; x2R <= '0; y2R <= '0;
    end else if (!busy) begin
      if (loadX1) x1R <= dataIn;
      if (loadY1) y1R <= dataIn;
      if (loadX2) x2R <= dataIn;
      if (loadY2) y2R <= dataIn;
    end
  end

  // setup values: spans per axis, produced by one generate loop
  logic signed [ERR_W-1:0] spanInit [2];
  logic                    negInit  [2];
  logic [COORD_W-1:0]      fromAxis [2];
  logic [COORD_W-1:0]      toAxis   [2];
  assign fromAxis[0] = x1R; assign toAxis[0] = x2R;
  assign fromAxis[1] = y1R; assign toAxis[1] = y2R;

  for (genvar a = 0; a < 2; a++) begin : g_axis
    logic signed [ERR_W-1:0] diff;
    assign diff        = $signed({{PAD_W{1'b0}}, toAxis[a]}) - $signed({{PAD_W{1'b0}}, fromAxis[a]});
    assign spanInit[a] = diff[ERR_W-1] ? -diff : diff;
    assign negInit[a]  = !(fromAxis[a] < toAxis[a]);
  end

  // step decision
  logic signed [ERR_W:0] e2, dxExt, dyExt;
  logic moveX, moveY;
  logic signed [ERR_W-1:0] errNext;
  always_comb begin
    e2      = $signed({errR, 1'b0});
    dxExt   = $signed({dxR[ERR_W-1], dxR});
    dyExt   = $signed({dyR[ERR_W-1], dyR});
    moveX   = e2 > -dyExt;
    moveY   = e2 < dxExt;
    errNext = errR - (moveX ? dyR : '0) + (moveY ? dxR : '0);
  end

  assign atEnd = (curX == x2R) && (curY == y2R);

  always_ff @(posedge clk) begin
    if (!resetn) begin
      curX <= '0; curY <= '0;
      dxR <= '0; dyR <= '0; errR <= '0;
      sxNeg <= 1'b0; syNeg <= 1'b0;
    end else if (cmd.init) begin
      curX  <= x1R;
      curY  <= y1R;
      dxR   <= spanInit[0];
      dyR   <= spanInit[1];
      errR  <= spanInit[0] - spanInit[1];
      sxNeg <= negInit[0];
      syNeg <= negInit[1];
    end else if (cmd.step) begin
      errR <= errNext;
      if (moveX) curX <= sxNeg ? curX - ONE : curX + ONE;
      if (moveY) curY <= syNeg ? curY - ONE : curY + ONE;
    end
  end

  // R3: setup puts the walker on the start point
  p_start_point_r3: assert property (@(posedge clk) disable iff (!resetn)
    cmd.init |=> (curX == $past(x1R)) && (curY == $past(y1R)));

  // R4: each step is a unit move on at least one axis
  p_unit_step_r4: assert property (@(posedge clk) disable iff (!resetn)
    cmd.step |=> ((curX == $past(curX)) || (curX == $past(curX) + ONE) || (curX == $past(curX) - ONE))
              && ((curY == $past(curY)) || (curY == $past(curY) + ONE) || (curY == $past(curY) - ONE))
              && !((curX == $past(curX)) && (curY == $past(curY))));

  // R8: endpoints frozen while drawing
  p_hold_endpoints_r8: assert property (@(posedge clk) disable iff (!resetn)
    busy |=> $stable(x1R) && $stable(y1R) && $stable(x2R) && $stable(y2R));
endmodule

// File: rtl/line_ctrl.sv
module line_ctrl
  import line_pkg::*;
(
  input  logic     clk,
  input  logic     resetn,
  input  logic     start,
  input  logic     atEnd,
  output lineCmd_t cmd,
  output logic     busy
);
  typedef enum logic {S_IDLE, S_DRAW} ctrlState_e;
  ctrlState_e state, stateNext;

  always_comb begin
    stateNext = state;
    cmd       = '0;
    unique case (state)
      S_IDLE: if (start) begin
        cmd.init  = 1'b1;
        stateNext = S_DRAW;
      end
      S_DRAW: if (atEnd) stateNext = S_IDLE;
              else       cmd.step  = 1'b1;
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!resetn) state <= S_IDLE;
    else         state <= stateNext;
  end

  assign busy = (state == S_DRAW);

  // R5: reaching the end point releases busy next cycle
  p_end_release_r5: assert property (@(posedge clk) disable iff (!resetn)
    (busy && atEnd) |=> !busy);

  // R4: no gap in output before the end point
  p_busy_holds_r4: assert property (@(posedge clk) disable iff (!resetn)
    (busy && !atEnd) |=> busy);

  // R3: idle start always launches a line
  p_start_launch_r3: assert property (@(posedge clk) disable iff (!resetn)
    (!busy && start) |=> busy);
endmodule

// File: rtl/line_pixel_gen.sv
module line_pixel_gen
  import line_pkg::*;
#(
  parameter int COORD_W = 10
) (
  input  logic               clk,
  input  logic               resetn,
  input  logic [COORD_W-1:0] dataIn,
  input  logic               loadX1,
  input  logic               loadY1,
  input  logic               loadX2,
  input  logic               loadY2,
  input  logic               start,
  output logic [COORD_W-1:0] pixelX,
  output logic [COORD_W-1:0] pixelY,
  output logic               pixelValid,
  output logic               busy
);
  lineCmd_t cmd;
  logic atEnd;
  logic busyInt;

  line_ctrl u_ctrl (
    .clk    (clk),
    .resetn (resetn),
    .start  (start),
    .atEnd  (atEnd),
    .cmd    (cmd),
    .busy   (busyInt)
  );

  line_datapath #(.COORD_W(COORD_W)) u_dp (
    .clk    (clk),
    .resetn (resetn),
    .dataIn (dataIn),
    .loadX1 (loadX1),
    .loadY1 (loadY1),
    .loadX2 (loadX2),
    .loadY2 (loadY2),
    .busy   (busyInt),
    .cmd    (cmd),
    .atEnd  (atEnd),
    .curX   (pixelX),
    .curY   (pixelY)
  );

  assign busy       = busyInt;
  assign pixelValid = busyInt;
endmodule

// File: tb/sim_line_pixel_gen.sv
`timescale 1ns/1ps
module sim_line_pixel_gen;
  localparam int CW = 10;
  localparam int MAXC = (1 << CW) - 1;

  logic clk = 1'b0;
  logic resetn = 1'b0;
  logic [CW-1:0] dataIn = '0;
  logic loadX1 = 0, loadY1 = 0, loadX2 = 0, loadY2 = 0, start = 0;
  logic [CW-1:0] pixelX, pixelY;
  logic pixelValid, busy;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  line_pixel_gen #(.COORD_W(CW)) u0 (
    .clk(clk), .resetn(resetn), .dataIn(dataIn),
    .loadX1(loadX1), .loadY1(loadY1), .loadX2(loadX2), .loadY2(loadY2),
    .start(start), .pixelX(pixelX), .pixelY(pixelY),
    .pixelValid(pixelValid), .busy(busy)
  );

  task automatic check(input bit ok, input string req, input string act, input string exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%s expected=%s", req, act, exp);
    end
  endtask

  task automatic loadOne(input int sel, input int val);
    @(negedge clk);
    dataIn = CW'(val);
    loadX1 = (sel == 0); loadY1 = (sel == 1);
    loadX2 = (sel == 2); loadY2 = (sel == 3);
    @(negedge clk);
    loadX1 = 0; loadY1 = 0; loadX2 = 0; loadY2 = 0;
  endtask

  // draw a line and compare each cycle against the arithmetic model
  task automatic runLine(input int ax, input int ay, input int bx, input int by,
                         input bit doLoad, input int disturbAt, input string tag);
    int x, y, dx, dy, sx, sy, err, e2, n, span;
    if (doLoad) begin
      loadOne(0, ax); loadOne(1, ay); loadOne(2, bx); loadOne(3, by);
    end
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    dx = (bx > ax) ? bx - ax : ax - bx;
    dy = (by > ay) ? by - ay : ay - by;
    sx = (ax < bx) ? 1 : -1;
    sy = (ay < by) ? 1 : -1;
    err = dx - dy;
    x = ax; y = ay; n = 0;
    forever begin
      if (n == disturbAt) begin
        // R8: strobes while busy
        dataIn = '0; start = 1; loadX2 = 1; loadY1 = 1;
      end
      check(pixelValid && busy && pixelX == CW'(x) && pixelY == CW'(y),
            (n == 0) ? "R3/R1" : {tag, "/R4"},
            $sformatf("v=%0b b=%0b (%0d,%0d) step %0d", pixelValid, busy, pixelX, pixelY, n),
            $sformatf("v=1 b=1 (%0d,%0d)", x, y));
      if (x == bx && y == by) break;
      e2 = 2 * err;
      if (e2 > -dy) begin err -= dy; x += sx; end
      if (e2 < dx)  begin err += dx; y += sy; end
      @(negedge clk);
      start = 0; loadX2 = 0; loadY1 = 0;
      n++;
      if (n > 4000) break;
    end
    @(negedge clk);
    check(!busy && !pixelValid, "R5", $sformatf("busy=%0b valid=%0b", busy, pixelValid), "busy=0 valid=0");
    span = (dx > dy) ? dx : dy;
    check(n + 1 == span + 1, "R10", $sformatf("%0d pixels", n + 1), $sformatf("%0d pixels", span + 1));
  endtask

  initial begin
    #750000;
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R2: reset state
    check(!busy && !pixelValid, "R2", $sformatf("busy=%0b valid=%0b", busy, pixelValid), "busy=0 valid=0");
    resetn = 1;
    repeat (2) @(negedge clk);
    check(!busy && !pixelValid, "R2", $sformatf("busy=%0b valid=%0b", busy, pixelValid), "idle low");

    // R6: reference line, with strobes injected mid-line (R8), then redraw (R9)
    runLine(787, 590, 647, 812, 1, 60, "R6");
    runLine(787, 590, 647, 812, 0, -1, "R9");

    // R7: degenerate line
    runLine(5, 5, 5, 5, 1, -1, "R7");
    runLine(MAXC, 0, MAXC, 0, 1, -1, "R7");

    // R10: full-range lines
    runLine(0, 0, MAXC, MAXC, 1, -1, "R10");
    runLine(MAXC, 0, 0, MAXC, 1, -1, "R10");
    runLine(0, 7, MAXC, 0, 1, -1, "R10");
    runLine(3, MAXC, 0, 0, 1, -1, "R10");

    // R6: exhaustive patches near both ends of the range
    for (int base = 0; base < 2; base++) begin
      for (int p = 0; p < 256; p++) begin
        int o;
        o = (base == 0) ? 0 : MAXC - 3;
        runLine(o + (p & 3), o + ((p >> 2) & 3), o + ((p >> 4) & 3), o + ((p >> 6) & 3), 1, -1, "R6");
      end
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule